// File: doc/BRIEF.md
# Serial Programming Command Target

This block is the target side of a three-wire in-system programming link. While the device is held in reset, a host clocks 32-bit instructions in on a data input against a serial clock and reads replies back on a data output. The block oversamples the serial clock and data with the system clock and counts bits into four-byte frames. It stays deaf to every command until it has seen a valid enable instruction. After that it turns each frame into a single write strobe or a read request on a plain memory-side port.

The memory-side port carries an operation code, a word or byte address and write data. It takes back combinational read data and a busy flag. Flash words are staged one byte at a time into a page buffer and later committed as a whole page. EEPROM bytes are written one at a time, and the memory performs the erase before the write. Reads return the addressed byte in the final byte of the same instruction.

Top module: `isp_cmd_slave`

## Requirements
- R1: The data input is taken on rising serial-clock edges, most significant bit first. The data output changes only after falling edges, so it is steady whenever the serial clock is high.
- R2: Every instruction is exactly 32 bits, and a frame that decodes to nothing still uses all of them. While `tgt_held` is low, the bit counter stays at zero, the enable state is cleared, the data output is 0 and serial-clock edges are ignored.
- R3: When the first byte is 0xAC, the second byte as received is sent back during the third byte. An instruction of 0xAC followed by 0x53 sets the enable state.
- R4: Until the enable state is set, no write strobe is issued and reads return 0x00.
- R5: A buffer low load has opcode 0x40. Byte 2 bits [3:0] select the word, and byte 3 is the data. It strobes with `mem_op` = 0.
- R6: A buffer high load has opcode 0x48 and strobes with `mem_op` = 1. It is accepted only if the previously accepted buffer load was a low load of the same word. In every other case it is dropped.
- R7: A page commit has opcode 0x4C. It strobes with `mem_op` = 2, and the address is {byte1[1:0], byte2} with its low 4 bits cleared.
- R8: An EEPROM write has opcode 0xC0. Byte 2 bits [6:0] are the address and byte 3 is the data. It issues exactly one strobe with `mem_op` = 3, and the stored byte equals the data whatever it held before.
- R9: Flash reads use opcode 0x20 for the low byte (`mem_op` 4) and 0x28 for the high byte (`mem_op` 5), at word address {byte1[1:0], byte2}. An EEPROM read uses opcode 0xA0 (`mem_op` 6) at address byte2[6:0]. The data goes out MSB first during byte 3. Reply bytes that carry neither an echo nor read data are 0x00.
- R10: A write instruction that completes while `mem_busy` is high produces no strobe.
- R11: `mem_we` is high for exactly one system clock per accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| tgt_held | input | 1 | High while the device is held in reset and programming is allowed |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| mem_we | output | 1 | One-cycle write strobe |
| mem_op | output | 3 | Operation code for the memory side |
| mem_addr | output | WORD_AW | Word, page or byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data for the current `mem_op` and `mem_addr` |
| mem_busy | input | 1 | Memory is still completing a commit or EEPROM write |

## Verification
The hardest state to reach from the ports is a link that has lost its bit alignment, because a well-behaved host never loses alignment. The bench creates it by giving a single stray serial-clock pulse before an enable instruction. It then checks that the shifted frame produces no echo. Next it pulses `tgt_held` low while toggling the serial clock, and checks that the link comes back aligned but disabled. Dropping a write under `mem_busy` is forced the same way: the bench sends a second EEPROM write immediately after the first, while the memory model is still busy.

// File: rtl/isp_cmd_slave.sv
module isp_cmd_slave #(
  parameter int WORD_AW = 10,
  parameter int PAGE_WB = 4,
  parameter int EE_AW   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tgt_held,
  input  logic               sck,
  input  logic               mosi,
  output logic               miso,
  output logic               mem_we,
  output logic [2:0]         mem_op,
  output logic [WORD_AW-1:0] mem_addr,
  output logic [7:0]         mem_wdata,
  input  logic [7:0]         mem_rdata,
  input  logic               mem_busy
);
  localparam logic [7:0] OP_EN   = 8'hAC;
  localparam logic [7:0] OP_SYNC = 8'h53;
  localparam logic [7:0] OP_LDL  = 8'h40;
  localparam logic [7:0] OP_LDH  = 8'h48;
  localparam logic [7:0] OP_PGW  = 8'h4C;
  localparam logic [7:0] OP_EEW  = 8'hC0;
  localparam logic [7:0] OP_RDL  = 8'h20;
  localparam logic [7:0] OP_RDH  = 8'h28;
  localparam logic [7:0] OP_EER  = 8'hA0;
  localparam logic [WORD_AW-1:0] PAGE_MASK = ~WORD_AW'((1 << PAGE_WB) - 1);

  logic [2:0] sck_q;
  logic [1:0] mosi_q;
  logic [4:0] bit_cnt;
  logic [6:0] rx;
  logic [7:0] b0, b1, b2, tx, nxt;
  logic       enabled, rd_pend, lo_ok;
  logic [PAGE_WB-1:0] lo_word;

  wire       sck_rise = sck_q[1] & ~sck_q[2];
  wire       sck_fall = ~sck_q[1] & sck_q[2];
  wire       din      = mosi_q[1];
  wire [7:0] byte_in  = {rx, din};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q  <= '0;
      mosi_q <= '0;
    end else begin
      sck_q  <= {sck_q[1:0], sck};
      mosi_q <= {mosi_q[0], mosi};
    end

  always_comb begin
    nxt = 8'h00;
    if (bit_cnt == 5'd16 && b0 == OP_EN) nxt = b1;
    else if (bit_cnt == 5'd24 && rd_pend) nxt = mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0; rx <= '0; b0 <= '0; b1 <= '0; b2 <= '0;
      tx <= '0; miso <= 1'b0; enabled <= 1'b0; rd_pend <= 1'b0;
      lo_ok <= 1'b0; lo_word <= '0;
      mem_we <= 1'b0; mem_op <= '0; mem_addr <= '0; mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (!tgt_held) begin
        bit_cnt <= '0; rx <= '0; tx <= '0; miso <= 1'b0;
        enabled <= 1'b0; rd_pend <= 1'b0; lo_ok <= 1'b0;
      end else begin
        if (sck_rise) begin
          bit_cnt <= bit_cnt + 5'd1;
          rx      <= {rx[5:0], din};
          case (bit_cnt)
            5'd7:  b0 <= byte_in;
            5'd15: b1 <= byte_in;
            5'd23: begin
              b2 <= byte_in;
              rd_pend <= enabled && (b0 == OP_RDL || b0 == OP_RDH || b0 == OP_EER);
              if (enabled) begin
                case (b0)
                  OP_RDL: begin mem_op <= 3'd4; mem_addr <= WORD_AW'({b1, byte_in}); end
                  OP_RDH: begin mem_op <= 3'd5; mem_addr <= WORD_AW'({b1, byte_in}); end
                  OP_EER: begin mem_op <= 3'd6; mem_addr <= WORD_AW'(byte_in[EE_AW-1:0]); end
                  default: ;
                endcase
              end
            end
            5'd31: begin
              rd_pend <= 1'b0;
              if (b0 == OP_EN && b1 == OP_SYNC) enabled <= 1'b1;
              else if (enabled && !mem_busy) begin
                case (b0)
                  OP_LDL: begin
                    mem_we <= 1'b1; mem_op <= 3'd0;
                    mem_addr <= WORD_AW'(b2[PAGE_WB-1:0]); mem_wdata <= byte_in;
                    lo_ok <= 1'b1; lo_word <= b2[PAGE_WB-1:0];
                  end
                  OP_LDH: begin
                    lo_ok <= 1'b0;
                    if (lo_ok && lo_word == b2[PAGE_WB-1:0]) begin
                      mem_we <= 1'b1; mem_op <= 3'd1;
                      mem_addr <= WORD_AW'(b2[PAGE_WB-1:0]); mem_wdata <= byte_in;
                    end
                  end
                  OP_PGW: begin
                    mem_we <= 1'b1; mem_op <= 3'd2;
                    mem_addr <= WORD_AW'({b1, b2}) & PAGE_MASK;
                  end
                  OP_EEW: begin
                    mem_we <= 1'b1; mem_op <= 3'd3;
                    mem_addr <= WORD_AW'(b2[EE_AW-1:0]); mem_wdata <= byte_in;
                  end
                  default: ;
                endcase
              end
            end
            default: ;
          endcase
        end
        if (sck_fall) begin
          if (bit_cnt[2:0] == 3'd0) begin
            miso <= nxt[7];
            tx   <= {nxt[6:0], 1'b0};
          end else begin
            miso <= tx[7];
            tx   <= {tx[6:0], 1'b0};
          end
        end
      end
    end
endmodule

// File: rtl/isp_cmd_slave_chk.sv
module isp_cmd_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tgt_held,
  input logic       sck,
  input logic       miso,
  input logic       mem_we,
  input logic [2:0] mem_op,
  input logic       mem_busy
);
  p_we_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  p_no_we_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(!mem_busy));
  p_quiet_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tgt_held && !$past(tgt_held)) |-> (!mem_we && !miso));
  p_miso_moves_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso) |-> !sck);
  p_write_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_op <= 3'd3));
endmodule

bind isp_cmd_slave isp_cmd_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tgt_held(tgt_held), .sck(sck), .miso(miso),
  .mem_we(mem_we), .mem_op(mem_op), .mem_busy(mem_busy)
);

// File: tb/isp_cmd_slave_bench.sv
module isp_cmd_slave_bench;
  localparam int HALF = 8;
  localparam int BUSY = 600;
  localparam int GAP  = 700;

  logic clk = 1'b0, rst_n = 1'b0, tgt_held = 1'b0, sck = 1'b0, mosi = 1'b0;
  logic miso, mem_we, mem_busy;
  logic [2:0] mem_op;
  logic [9:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  int checks = 0, errors = 0, we_cnt = 0, we_long = 0, miso_hi_moves = 0, cyc = 0, busy_cnt = 0;
  logic prev_we = 1'b0, prev_miso = 1'b0;
  logic [15:0] flash [1024];
  logic [15:0] pbuf [16];
  logic [7:0]  ee [128];

  always #10 clk = ~clk;

  isp_cmd_slave u_isp_cmd_slave (
    .clk(clk), .rst_n(rst_n), .tgt_held(tgt_held), .sck(sck), .mosi(mosi), .miso(miso),
    .mem_we(mem_we), .mem_op(mem_op), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_busy(mem_busy)
  );

  assign mem_busy = busy_cnt != 0;
  always_comb begin
    case (mem_op)
      3'd4:    mem_rdata = flash[mem_addr][7:0];
      3'd5:    mem_rdata = flash[mem_addr][15:8];
      3'd6:    mem_rdata = ee[mem_addr[6:0]];
      default: mem_rdata = 8'h00;
    endcase
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (busy_cnt > 0) busy_cnt = busy_cnt - 1;
    if (rst_n && mem_we && prev_we) we_long = we_long + 1;
    if (rst_n && miso !== prev_miso && sck) miso_hi_moves = miso_hi_moves + 1;
    prev_we = mem_we;
    prev_miso = miso;
    if (mem_we) begin
      we_cnt = we_cnt + 1;
      case (mem_op)
        3'd0: pbuf[mem_addr[3:0]][7:0] = mem_wdata;
        3'd1: pbuf[mem_addr[3:0]][15:8] = mem_wdata;
        3'd2: begin
          for (int i = 0; i < 16; i++) flash[{mem_addr[9:4], 4'(i)}] = pbuf[i];
          busy_cnt = BUSY;
        end
        3'd3: begin
          ee[mem_addr[6:0]] = 8'hFF;
          ee[mem_addr[6:0]] = mem_wdata;
          busy_cnt = BUSY;
        end
        default: ;
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] cmd, output logic [31:0] resp);
    for (int i = 31; i >= 0; i--) begin
      mosi = cmd[i];
      repeat (HALF) @(negedge clk);
      resp[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
  endtask

  task automatic pulse_sck(input int n);
    for (int i = 0; i < n; i++) begin
      mosi = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
  endtask

  // {requirement number, instruction, expected reply, expected strobe count}
  localparam logic [69:0] VEC [19] = '{
    {4'd4, 32'h2000_0000, 32'h0000_0000, 2'd0},  // R4 read before enable
    {4'd4, 32'hC000_0577, 32'h0000_0000, 2'd0},  // R4 write before enable
    {4'd3, 32'hAC53_0000, 32'h0000_5300, 2'd0},  // R3 enable with echo
    {4'd9, 32'h2000_0000, 32'h0000_00EF, 2'd0},  // R9 flash low
    {4'd9, 32'h2800_0000, 32'h0000_00BE, 2'd0},  // R9 flash high
    {4'd4, 32'hA000_0500, 32'h0000_00FF, 2'd0},  // R4 earlier write had no effect
    {4'd8, 32'hC000_053C, 32'h0000_0000, 2'd1},  // R8 eeprom write
    {4'd8, 32'hA000_0500, 32'h0000_003C, 2'd0},  // R8 readback
    {4'd5, 32'h4000_0311, 32'h0000_0000, 2'd1},  // R5 low load word 3
    {4'd6, 32'h4800_0322, 32'h0000_0000, 2'd1},  // R6 high load after low
    {4'd6, 32'h4800_0499, 32'h0000_0000, 2'd0},  // R6 high load without low
    {4'd5, 32'h4000_0455, 32'h0000_0000, 2'd1},  // R5 low load word 4
    {4'd7, 32'h4C00_1000, 32'h0000_0000, 2'd1},  // R7 commit page 1
    {4'd5, 32'h2000_1300, 32'h0000_0011, 2'd0},  // R5 committed low byte
    {4'd6, 32'h2800_1300, 32'h0000_0022, 2'd0},  // R6 committed high byte
    {4'd6, 32'h2800_1400, 32'h0000_00FF, 2'd0},  // R6 dropped high byte
    {4'd7, 32'h2000_1400, 32'h0000_0055, 2'd0},  // R7 whole page moved
    {4'd7, 32'h2000_0000, 32'h0000_00EF, 2'd0},  // R7 other page untouched
    {4'd3, 32'hAC99_0000, 32'h0000_9900, 2'd0}   // R3 echo of any second byte
  };

  initial begin
    logic [31:0] r;
    int w0;
    for (int i = 0; i < 1024; i++) flash[i] = 16'hFFFF;
    for (int i = 0; i < 16; i++) pbuf[i] = 16'hFFFF;
    for (int i = 0; i < 128; i++) ee[i] = 8'hFF;
    flash[0] = 16'hBEEF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(miso == 1'b0 && mem_we == 1'b0, "R2 reset state", {30'd0, miso, mem_we}, 32'd0);
    tgt_held = 1'b1;
    repeat (20) @(negedge clk);

    for (int v = 0; v < 19; v++) begin
      w0 = we_cnt;
      xfer(VEC[v][65:34], r);
      chk(r == VEC[v][33:2], $sformatf("R%0d vector %0d reply", VEC[v][69:66], v), r, VEC[v][33:2]);
      chk(we_cnt - w0 == int'(VEC[v][1:0]), $sformatf("R%0d vector %0d strobes", VEC[v][69:66], v),
          32'(we_cnt - w0), 32'(VEC[v][1:0]));
      repeat (GAP) @(negedge clk);
    end

    // R10: second write lands while the first is still busy
    w0 = we_cnt;
    xfer(32'hC000_06AA, r);
    xfer(32'hC000_07BB, r);
    chk(we_cnt - w0 == 1, "R10 strobes under busy", 32'(we_cnt - w0), 32'd1);
    repeat (GAP) @(negedge clk);
    xfer(32'hA000_0700, r);
    chk(r == 32'h0000_00FF, "R10 dropped byte", r, 32'h0000_00FF);
    xfer(32'hA000_0600, r);
    chk(r == 32'h0000_00AA, "R8 accepted byte", r, 32'h0000_00AA);

    // R2: stray bit misaligns the frame
    pulse_sck(1);
    w0 = 0;
    mosi = 1'b0;
    xfer(32'hAC53_0000, r);
    chk(r == 32'h0000_0000, "R2 misaligned enable gives no echo", r, 32'h0000_0000);
    tgt_held = 1'b0;
    repeat (10) @(negedge clk);
    pulse_sck(5);
    chk(miso == 1'b0, "R2 output low while released", {31'd0, miso}, 32'd0);
    tgt_held = 1'b1;
    repeat (10) @(negedge clk);
    xfer(32'h2000_0000, r);
    chk(r == 32'h0000_0000, "R4 enable cleared by release", r, 32'h0000_0000);
    xfer(32'hAC53_0000, r);
    chk(r == 32'h0000_5300, "R2 realigned echo", r, 32'h0000_5300);
    xfer(32'h2000_0000, r);
    chk(r == 32'h0000_00EF, "R9 read after re-enable", r, 32'h0000_00EF);

    chk(we_long == 0, "R11 strobe width", 32'(we_long), 32'd0);
    chk(miso_hi_moves == 0, "R1 output steady while clock high", 32'(miso_hi_moves), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule